// File: doc/BRIEF.md
# Translation Table Pointer Generator

This block serves a software translation-miss handler. It keeps a table configuration register and a tag-access register. From these it forms two byte addresses into an in-memory translation table: one for an 8 KB page and one for a 64 KB page. The configuration register holds a table base, a layout bit and a 3-bit size code. The tag-access register holds the upper virtual-address bits and a 13-bit context.

Two sources load the tag-access register. A hardware capture input loads it when the core takes a translation miss, an exception or a protection fault. A software write loads it to stage a tag before a translation entry is written. A 2-bit read select chooses which of four values appears on a combinational read port: the configuration, the tag, the small-page pointer or the large-page pointer.

The layout bit selects how the large-page pointer is formed. When it is clear, both page sizes share the lines of one table. When it is set, the large-page entries sit in a second table of equal size that lies directly above the first. Each table entry is 16 bytes. A table holds 512 << size entries.

Top module: `tsb_ptr_unit`

## Requirements
- R1: After a synchronous active-low reset, the configuration register and the tag-access register are zero, so all four read selections return 0.
- R2: A configuration write loads three fields: base (bits 63:13), layout bit (bit 12) and size code (bits 2:0). Read select 0 returns them at those positions, with bits 11:3 reading zero.
- R3: The small-page pointer is the base with bits [12+N:0] cleared, ORed with VA[21+N:13] shifted left by 4, where N is the size code. It does not depend on the layout bit.
- R4: With the layout bit clear, the large-page pointer is the base with bits [12+N:0] cleared, ORed with VA[24+N:16] shifted left by 4.
- R5: With the layout bit set, the large-page pointer is the R4 value with bit 13+N also set, so it points into the upper table.
- R6: The index covers 9+N VA bits, from 512 entries at N=0 to 65536 entries at N=7. Higher VA bits do not reach the pointer.
- R7: A capture pulse loads the tag-access register with the capture VA bits 63:13 and the capture context.
- R8: A software tag write loads the VA bits and the context. Read select 1 returns VA bits 63:13 above the 13-bit context in bits 12:0.
- R9: When a capture and a software tag write occur in the same cycle, the capture values are stored.
- R10: In a cycle with no write to a register, that register keeps its value.
- R11: In the cycle after a configuration or tag write, both pointers already reflect the new value.
- R12: The read select codes are 0 for configuration, 1 for tag access, 2 for the small-page pointer and 3 for the large-page pointer.
- R13: With the layout bit clear, an 8 KB page at VA 0x2000 and a 64 KB page at VA 0x10000 both produce the pointer to table line 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_base | input | ADDR_W-13 | Table base, address bits 63:13 |
| cfg_wr_split | input | 1 | Layout bit: 1 selects two abutting tables |
| cfg_wr_size | input | SIZE_W | Size code N |
| tag_wr_en | input | 1 | Software tag-access write strobe |
| tag_wr_vpn | input | ADDR_W-13 | Software VA bits 63:13 |
| tag_wr_ctx | input | CTX_W | Software context |
| cap_en | input | 1 | Hardware capture on miss or fault |
| cap_vpn | input | ADDR_W-13 | Faulting VA bits 63:13 |
| cap_ctx | input | CTX_W | Faulting context |
| rd_sel | input | 2 | Read select |
| rd_data | output | ADDR_W | Selected register or pointer |

## Verification
The bench probes size codes 0, 3 and 7, each with the layout bit clear and set. Wrong index masking therefore shows up as stray high VA bits in the pointer, and a mis-sized base mask shows up as lost or kept base bits. The base values are chosen so that a layout bit wrongly added to the small-page pointer, or placed one bit off in the large-page pointer, changes the result. It drives a capture and a software write in the same cycle, so a design with the wrong priority stores the software tag. It replays the aliasing pair at VA 0x2000 and 0x10000, where a design that mixed up the index shifts would point at different lines.

// File: rtl/tsb_ptr_pkg.sv
// Package: shared constants and the read-select encoding of the pointer unit.
// Assumes the smallest page is 8 KB and that table entries are 16 bytes.
package tsb_ptr_pkg;
    localparam int unsigned PAGE_SHIFT     = 13;  // 8 KB page offset width
    localparam int unsigned BIG_SHIFT      = 16;  // 64 KB page offset width
    localparam int unsigned ENTRY_SHIFT    = 4;   // 16-byte entries
    localparam int unsigned MIN_ENTRY_LOG2 = 9;   // 512 entries at size 0
    localparam int unsigned SPLIT_POS      = 12;  // layout bit in config readback

    typedef enum logic [1:0] {
        RD_CFG   = 2'd0,
        RD_TAG   = 2'd1,
        RD_SMALL = 2'd2,
        RD_BIG   = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/tsb_cfg_reg.sv
// Table configuration register: holds the base, layout bit and size code.
// Assumes the base is supplied already without its page-offset bits.
module tsb_cfg_reg #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned SIZE_W = 3,
    localparam int unsigned VPN_W = ADDR_W - tsb_ptr_pkg::PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [VPN_W-1:0]  wr_base,
    input  logic              wr_split,
    input  logic [SIZE_W-1:0] wr_size,
    output logic [ADDR_W-1:0] base,
    output logic              split,
    output logic [SIZE_W-1:0] size
);
    import tsb_ptr_pkg::*;

    logic [VPN_W-1:0] base_q;

    // Load all three fields on a write, clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            split  <= 1'b0;
            size   <= '0;
        end else if (wr_en) begin
            base_q <= wr_base;
            split  <= wr_split;
            size   <= wr_size;
        end
    end

    // Present the base as a full byte address.
    assign base = {base_q, {PAGE_SHIFT{1'b0}}};

    p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (base[ADDR_W-1:PAGE_SHIFT] == $past(wr_base)) &&
                  (split == $past(wr_split)) && (size == $past(wr_size)));

    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(base) && $stable(split) && $stable(size));
endmodule

// File: rtl/tsb_tag_reg.sv
// Tag-access register: VA bits above the 8 KB offset plus a context.
// Hardware capture wins over a software write in the same cycle.
module tsb_tag_reg #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned CTX_W  = 13,
    localparam int unsigned VPN_W = ADDR_W - tsb_ptr_pkg::PAGE_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [VPN_W-1:0] cap_vpn,
    input  logic [CTX_W-1:0] cap_ctx,
    input  logic             sw_en,
    input  logic [VPN_W-1:0] sw_vpn,
    input  logic [CTX_W-1:0] sw_ctx,
    output logic [VPN_W-1:0] vpn,
    output logic [CTX_W-1:0] ctx
);
    // Capture has priority; otherwise a software write loads the register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn <= '0;
            ctx <= '0;
        end else if (cap_en) begin
            vpn <= cap_vpn;
            ctx <= cap_ctx;
        end else if (sw_en) begin
            vpn <= sw_vpn;
            ctx <= sw_ctx;
        end
    end

    p_tag_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (vpn == $past(cap_vpn)) && (ctx == $past(cap_ctx)));

    p_tag_sw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && !cap_en) |=> (vpn == $past(sw_vpn)) && (ctx == $past(sw_ctx)));

    p_cap_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && cap_en) |=> (ctx == $past(cap_ctx)));

    p_tag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_en && !cap_en) |=> $stable(vpn) && $stable(ctx));
endmodule

// File: rtl/tsb_ptr_calc.sv
// Pointer former for one page size: masks the base to the table size,
// inserts the VA index as a 16-byte entry offset and, for the large-page
// variant in split layout, selects the upper abutting table.
module tsb_ptr_calc #(
    parameter int unsigned ADDR_W    = 64,
    parameter int unsigned SIZE_W    = 3,
    parameter int unsigned IDX_SHIFT = 13,
    parameter bit          USE_SPLIT = 1'b0
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              split,
    input  logic [SIZE_W-1:0] size,
    input  logic [ADDR_W-1:0] va,
    output logic [ADDR_W-1:0] ptr
);
    import tsb_ptr_pkg::*;

    localparam logic [ADDR_W-1:0] ONES = '1;

    int unsigned       tbl_lsb;
    int unsigned       idx_bits;
    logic [ADDR_W-1:0] base_keep;
    logic [ADDR_W-1:0] idx;
    logic [ADDR_W-1:0] upper;

    // Derive table extent from the size code, then assemble the pointer.
    always_comb begin
        tbl_lsb   = PAGE_SHIFT + 32'(size);
        idx_bits  = MIN_ENTRY_LOG2 + 32'(size);
        base_keep = ONES << tbl_lsb;
        idx       = (va >> IDX_SHIFT) & ~(ONES << idx_bits);
        upper     = (USE_SPLIT && split) ? (ADDR_W'(1) << tbl_lsb) : '0;
        ptr       = (base & base_keep) | (idx << ENTRY_SHIFT) | upper;
    end
endmodule

// File: rtl/tsb_ptr_unit.sv
// Top: configuration and tag-access registers, two pointer formers and a
// combinational read port. Assumes CTX_W <= 13 and ADDR_W >= 40.
module tsb_ptr_unit #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned SIZE_W = 3,
    parameter int unsigned CTX_W  = 13,
    localparam int unsigned VPN_W = ADDR_W - tsb_ptr_pkg::PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [VPN_W-1:0]  cfg_wr_base,
    input  logic              cfg_wr_split,
    input  logic [SIZE_W-1:0] cfg_wr_size,
    input  logic              tag_wr_en,
    input  logic [VPN_W-1:0]  tag_wr_vpn,
    input  logic [CTX_W-1:0]  tag_wr_ctx,
    input  logic              cap_en,
    input  logic [VPN_W-1:0]  cap_vpn,
    input  logic [CTX_W-1:0]  cap_ctx,
    input  logic [1:0]        rd_sel,
    output logic [ADDR_W-1:0] rd_data
);
    import tsb_ptr_pkg::*;

    logic [ADDR_W-1:0] base;
    logic              split;
    logic [SIZE_W-1:0] size;
    logic [VPN_W-1:0]  vpn;
    logic [CTX_W-1:0]  ctx;
    logic [ADDR_W-1:0] va;
    logic [ADDR_W-1:0] ptr [2];
    logic [ADDR_W-1:0] cfg_view;
    logic [ADDR_W-1:0] tag_view;

    tsb_cfg_reg #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en),
        .wr_base(cfg_wr_base), .wr_split(cfg_wr_split), .wr_size(cfg_wr_size),
        .base(base), .split(split), .size(size)
    );

    tsb_tag_reg #(.ADDR_W(ADDR_W), .CTX_W(CTX_W)) tag_i (
        .clk(clk), .rst_n(rst_n),
        .cap_en(cap_en), .cap_vpn(cap_vpn), .cap_ctx(cap_ctx),
        .sw_en(tag_wr_en), .sw_vpn(tag_wr_vpn), .sw_ctx(tag_wr_ctx),
        .vpn(vpn), .ctx(ctx)
    );

    assign va = {vpn, {PAGE_SHIFT{1'b0}}};

    // One former per page size: index 0 is 8 KB, index 1 is 64 KB.
    for (genvar g = 0; g < 2; g++) begin : g_ptr
        tsb_ptr_calc #(
            .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
            .IDX_SHIFT(g == 0 ? PAGE_SHIFT : BIG_SHIFT),
            .USE_SPLIT(g == 1)
        ) calc_i (
            .base(base), .split(split), .size(size), .va(va), .ptr(ptr[g])
        );
    end

    // Build the software-visible views of the two registers.
    always_comb begin
        cfg_view = base;
        cfg_view[SPLIT_POS] = split;
        cfg_view[SIZE_W-1:0] = size;
        tag_view = va | ADDR_W'(ctx);
    end

    // Read port multiplexer.
    always_comb begin
        case (rd_sel_e'(rd_sel))
            RD_CFG:   rd_data = cfg_view;
            RD_TAG:   rd_data = tag_view;
            RD_SMALL: rd_data = ptr[0];
            default:  rd_data = ptr[1];
        endcase
    end

    p_big_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
        split |-> ptr[1][PAGE_SHIFT + 32'(size)]);

    p_big_common_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !split |-> (ptr[1][PAGE_SHIFT + 32'(size)] == base[PAGE_SHIFT + 32'(size)]));
endmodule

// File: tb/tsb_ptr_unit_tb_top.sv
`timescale 1ns/1ps
module tsb_ptr_unit_tb_top;
    localparam int NV = 7;
    localparam logic [63:0] V_CFG [NV] = '{
        64'h4000_0000, 64'h4000_0000, 64'h4000_1000,
        64'h1_0000_0007, 64'h1_0000_1007, 64'h7FFF_E003, 64'h7FF8_1003};
    localparam logic [63:0] V_VA [NV] = '{
        64'h2000, 64'h1_0000, 64'h1_0000,
        64'h3FFF_E000, 64'h3FFF_E000, 64'hFFFF_FFFF_FFFF_E000, 64'hFFFF_FFFF_FFFF_E000};
    localparam logic [63:0] V_P8 [NV] = '{
        64'h4000_0010, 64'h4000_0080, 64'h4000_0080,
        64'h1_000F_FFF0, 64'h1_000F_FFF0, 64'h7FFF_FFF0, 64'h7FF8_FFF0};
    localparam logic [63:0] V_P64 [NV] = '{
        64'h4000_0000, 64'h4000_0010, 64'h4000_2010,
        64'h1_0003_FFF0, 64'h1_0013_FFF0, 64'h7FFF_FFF0, 64'h7FF9_FFF0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [50:0] cfg_wr_base = '0;
    logic        cfg_wr_split = 1'b0;
    logic [2:0]  cfg_wr_size = '0;
    logic        tag_wr_en = 1'b0;
    logic [50:0] tag_wr_vpn = '0;
    logic [12:0] tag_wr_ctx = '0;
    logic        cap_en = 1'b0;
    logic [50:0] cap_vpn = '0;
    logic [12:0] cap_ctx = '0;
    logic [1:0]  rd_sel = '0;
    logic [63:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tsb_ptr_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_base(cfg_wr_base),
        .cfg_wr_split(cfg_wr_split), .cfg_wr_size(cfg_wr_size),
        .tag_wr_en(tag_wr_en), .tag_wr_vpn(tag_wr_vpn), .tag_wr_ctx(tag_wr_ctx),
        .cap_en(cap_en), .cap_vpn(cap_vpn), .cap_ctx(cap_ctx),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] sel, output logic [63:0] v);
        rd_sel = sel;
        #0.5;
        v = rd_data;
    endtask

    // Write config and tag in one cycle; registers update at the next edge.
    task automatic load(input logic [63:0] cfg, input logic [63:0] va);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_base = cfg[63:13];
        cfg_wr_split = cfg[12]; cfg_wr_size = cfg[2:0];
        tag_wr_en = 1'b1; tag_wr_vpn = va[63:13]; tag_wr_ctx = '0;
        @(negedge clk);
        cfg_wr_en = 1'b0; tag_wr_en = 1'b0;
    endtask

    initial begin
        logic [63:0] v, a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, all four selections
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v);
            check("R1 reset value", v, 64'h0);
        end
        // Vector table: R3 R4 R5 R6 R11 R12
        for (int i = 0; i < NV; i++) begin
            load(V_CFG[i], V_VA[i]);
            rd(2'd0, v); check("R2 config readback", v, V_CFG[i]);
            rd(2'd2, v); check("R3 R6 R11 small pointer", v, V_P8[i]);
            rd(2'd3, v);
            check(V_CFG[i][12] ? "R5 R6 R11 big pointer split" : "R4 R6 R11 big pointer common",
                  v, V_P64[i]);
        end
        // R13 aliasing pair with common layout
        load(64'h4000_0000, 64'h2000);
        rd(2'd2, a);
        load(64'h4000_0000, 64'h1_0000);
        rd(2'd3, b);
        check("R13 alias small vs big", a, b);
        check("R13 alias line 1", b, 64'h4000_0010);
        // R2 unused config bits read zero
        load(64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        rd(2'd0, v); check("R2 reserved bits zero", v, 64'hFFFF_FFFF_FFFF_F007);
        // R8 software tag write and readback layout
        @(negedge clk);
        tag_wr_en = 1'b1; tag_wr_vpn = 51'(64'hABCD_E000 >> 13); tag_wr_ctx = 13'h1555;
        @(negedge clk);
        tag_wr_en = 1'b0;
        rd(2'd1, v); check("R8 R12 tag readback", v, 64'hABCD_F555);
        // R7 capture alone
        @(negedge clk);
        cap_en = 1'b1; cap_vpn = 51'(64'h2ABC >> 13); cap_ctx = 13'h1FFF;
        @(negedge clk);
        cap_en = 1'b0;
        rd(2'd1, v); check("R7 capture load", v, 64'h3FFF);
        // R10 hold with no write
        repeat (2) @(negedge clk);
        rd(2'd1, v); check("R10 tag hold", v, 64'h3FFF);
        rd(2'd0, v); check("R10 config hold", v, 64'hFFFF_FFFF_FFFF_F007);
        // R9 capture beats a software write in the same cycle
        @(negedge clk);
        cap_en = 1'b1; cap_vpn = 51'(64'h1234_0000 >> 13); cap_ctx = 13'h7;
        tag_wr_en = 1'b1; tag_wr_vpn = 51'(64'h5000 >> 13); tag_wr_ctx = 13'h1;
        @(negedge clk);
        cap_en = 1'b0; tag_wr_en = 1'b0;
        rd(2'd1, v); check("R9 capture priority", v, 64'h1234_0007);
        // R11 R3 small pointer independent of layout bit after a config change
        load(64'h4000_0000, 64'h6000);
        rd(2'd2, a);
        load(64'h4000_1000, 64'h6000);
        rd(2'd2, b);
        check("R3 R11 small ignores layout", b, a);
        check("R3 small pointer line 3", b, 64'h4000_0030);
        // R1 reset clears after use
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(2'd3, v); check("R1 reset clears big pointer", v, 64'h0);
        rd(2'd1, v); check("R1 reset clears tag", v, 64'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule